// File: doc/BRIEF.md
# Third-Order Clock-Steering Loop Filter

This block sits between a digital phase comparator and a delta-sigma modulator in a clock-steering loop. Each time the loop update strobe fires, it takes the signed phase difference between the reference synthesizer and the steered synthesizer. It advances a type-3 filter and registers a signed frequency-adjustment word for the modulator that drives the oscillator control voltage. The filter has three accumulating paths: a proportional term, a rate (first integral) term and an acceleration (second integral) term. Because of the acceleration path, the frequency command follows phase ramps and phase acceleration with no steady-state error.

The three gains come in as plain signed inputs, so the loop bandwidth can be retuned at any time. A shorter strobe period makes the loop lock faster. A holdover input freezes the filter, for example while the phase measurement cannot be trusted. A lock flag reports that the phase error has stayed below a programmable magnitude for a run of consecutive updates.

Top module: `steer_loop_filter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the output word, the lock flag, both accumulators and the lock run counter are cleared to zero after that edge.
- R2: On each accepted update (strobe_i high and freeze_i low at a rising edge), the acceleration accumulator becomes its previous value plus gain_accel_i times phase_err_i.
- R3: On each accepted update, the rate accumulator becomes its previous value plus gain_rate_i times phase_err_i plus the acceleration accumulator's value from before that update.
- R4: On each accepted update, freq_adj_o is registered as gain_prop_i times phase_err_i plus the newly updated rate accumulator, and it is visible after that edge. Without an accepted update, freq_adj_o and locked_o keep their values.
- R5: Both accumulators saturate at the signed ACC_W-bit limits, -2^(ACC_W-1) and 2^(ACC_W-1)-1, and never wrap.
- R6: freq_adj_o saturates at the signed OUT_W-bit limits, -2^(OUT_W-1) and 2^(OUT_W-1)-1.
- R7: While freeze_i is high, strobes are ignored. The accumulators, freq_adj_o, locked_o and the lock run counter all keep their values.
- R8: locked_o rises on the accepted update that completes LOCK_RUN consecutive accepted updates whose error magnitude is strictly below lock_thresh_i. The magnitude of the most negative error is 2^(ERR_W-1).
- R9: An accepted update whose error magnitude is equal to or above lock_thresh_i clears locked_o and restarts the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Loop update strobe, one cycle per update period |
| freeze_i | input | 1 | Holdover: hold the filter state and the outputs |
| phase_err_i | input | ERR_W | Signed phase error sample |
| gain_prop_i | input | COEF_W | Signed proportional gain |
| gain_rate_i | input | COEF_W | Signed rate-path gain |
| gain_accel_i | input | COEF_W | Signed acceleration-path gain |
| lock_thresh_i | input | ERR_W | Unsigned error magnitude threshold for lock |
| freq_adj_o | output | OUT_W | Signed frequency-adjustment word |
| locked_o | output | 1 | Lock indicator |

## Verification
The bench builds the filter with ERR_W=10, COEF_W=8, ACC_W=20, OUT_W=20 and the default LOCK_RUN of 64. With these values, a 127 by 511 product fills the acceleration accumulator in about nine updates, so both accumulator limits and both output limits are reached within a few hundred cycles. Because the output word is as wide as the accumulators, a zero proportional gain exposes the saturated rate accumulator directly at the output. That shows the accumulators clamp rather than wrap. The 64-update lock run is exercised at full length, with strobes back to back, including a sample exactly at the threshold and the most negative error code.

// File: rtl/steer_lf_pkg.sv
// Package: shared constants and types for the clock-steering loop filter.
// Assumes nothing beyond IEEE 1800-2017.
package steer_lf_pkg;

    // Number of gain paths and their positions in the gain array
    localparam int unsigned NUM_GAINS = 3;
    localparam int unsigned G_PROP    = 0;
    localparam int unsigned G_RATE    = 1;
    localparam int unsigned G_ACCEL   = 2;

    // Result of a saturation decision
    typedef enum logic [1:0] {
        SAT_NONE = 2'b00,
        SAT_HIGH = 2'b01,
        SAT_LOW  = 2'b10
    } sat_dir_e;

endpackage

// File: rtl/lf_gain_mul.sv
// lf_gain_mul: signed product of one phase error sample and one gain.
// Purely combinational. Its output is wide enough that it cannot overflow.
module lf_gain_mul #(
    parameter int unsigned ERR_W  = 16,
    parameter int unsigned COEF_W = 12,
    localparam int unsigned PROD_W = ERR_W + COEF_W
) (
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic signed [COEF_W-1:0] gain_i,
    output logic signed [PROD_W-1:0] prod_o
);

    // Full-precision signed multiply
    always_comb begin
        prod_o = PROD_W'(err_i) * PROD_W'(gain_i);
    end

endmodule

// File: rtl/lf_sat_add.sv
// lf_sat_add: three-operand signed adder whose result is clamped to W bits.
// Computes base + inc + carry with two guard bits, then limits the result
// to the signed W-bit range. Combinational, so the caller owns the register.
module lf_sat_add
    import steer_lf_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 28,
    localparam int unsigned MW = (W > IW) ? W : IW,
    localparam int unsigned SW = MW + 2
) (
    input  logic signed [W-1:0]  base_i,
    input  logic signed [IW-1:0] inc_i,
    input  logic signed [W-1:0]  carry_i,
    output logic signed [W-1:0]  sum_o
);

    localparam logic signed [SW-1:0] HI_LIM = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] LO_LIM = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [SW-1:0] ext_base;
    logic signed [SW-1:0] ext_inc;
    logic signed [SW-1:0] ext_carry;
    logic signed [SW-1:0] wide_sum;
    sat_dir_e             dir;

    // Sign-extend the operands and form the wide sum
    always_comb begin
        ext_base  = base_i;
        ext_inc   = inc_i;
        ext_carry = carry_i;
        wide_sum  = ext_base + ext_inc + ext_carry;
    end

    // Decide whether the wide sum leaves the W-bit range
    always_comb begin
        if (wide_sum > HI_LIM) begin
            dir = SAT_HIGH;
        end else if (wide_sum < LO_LIM) begin
            dir = SAT_LOW;
        end else begin
            dir = SAT_NONE;
        end
    end

    // Select either the clamped limit or the in-range sum
    always_comb begin
        case (dir)
            SAT_HIGH: sum_o = HI_LIM[W-1:0];
            SAT_LOW:  sum_o = LO_LIM[W-1:0];
            default:  sum_o = wide_sum[W-1:0];
        endcase
    end

endmodule

// File: rtl/lf_out_stage.sv
// lf_out_stage: adds the proportional product to the updated rate
// accumulator, clamps the sum to the signed OUT_W range and registers it
// when en is high. Assumes OUT_W <= IW + 2.
module lf_out_stage
    import steer_lf_pkg::*;
#(
    parameter int unsigned IW    = 32,
    parameter int unsigned PW    = 28,
    parameter int unsigned OUT_W = 24,
    localparam int unsigned MW = (IW > PW) ? IW : PW,
    localparam int unsigned SW = MW + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [PW-1:0]    prop_i,
    input  logic signed [IW-1:0]    base_i,
    output logic signed [OUT_W-1:0] q_o
);

    localparam logic signed [SW-1:0] HI_LIM = {{(SW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [SW-1:0] LO_LIM = {{(SW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [SW-1:0]    ext_prop;
    logic signed [SW-1:0]    ext_base;
    logic signed [SW-1:0]    wide_sum;
    logic signed [OUT_W-1:0] clamped;
    sat_dir_e                dir;

    // Wide sum of the proportional term and the rate accumulator
    always_comb begin
        ext_prop = prop_i;
        ext_base = base_i;
        wide_sum = ext_prop + ext_base;
    end

    // Clamp to the output word range
    always_comb begin
        dir = SAT_NONE;
        if (wide_sum > HI_LIM) begin
            dir = SAT_HIGH;
        end else if (wide_sum < LO_LIM) begin
            dir = SAT_LOW;
        end
        case (dir)
            SAT_HIGH: clamped = HI_LIM[OUT_W-1:0];
            SAT_LOW:  clamped = LO_LIM[OUT_W-1:0];
            default:  clamped = wide_sum[OUT_W-1:0];
        endcase
    end

    // Output register, loaded only on accepted updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (en) begin
            q_o <= clamped;
        end
    end

endmodule

// File: rtl/lf_lock_det.sv
// lf_lock_det: counts consecutive enabled samples whose magnitude is
// strictly below a threshold and raises the lock flag once the count reaches
// RUN_LEN. One sample at or above the threshold clears the count and the
// flag. Assumes RUN_LEN >= 1.
module lf_lock_det #(
    parameter int unsigned ERR_W   = 16,
    parameter int unsigned RUN_LEN = 64,
    localparam int unsigned CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic        [ERR_W-1:0] thresh_i,
    output logic                    locked_o
);

    localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

    logic [ERR_W-1:0] mag;
    logic             below;
    logic [CNT_W-1:0] run_cnt;

    // Magnitude of the error; the most negative code maps to 2^(ERR_W-1)
    always_comb begin
        mag   = err_i[ERR_W-1] ? (~$unsigned(err_i) + 1'b1) : $unsigned(err_i);
        below = (mag < thresh_i);
    end

    // Run counter and lock flag, updated once per enabled sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            locked_o <= 1'b0;
        end else if (en) begin
            if (below) begin
                if (run_cnt != RUN_MAX) begin
                    run_cnt <= run_cnt + 1'b1;
                end
                locked_o <= (run_cnt >= RUN_LAST);
            end else begin
                run_cnt  <= '0;
                locked_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/steer_loop_filter.sv
// steer_loop_filter: third-order (type-3) loop filter for clock steering.
// On each accepted update it advances the acceleration and rate
// accumulators, registers the saturated frequency-adjustment word and
// updates the lock detector. freeze_i holds all state (holdover).
// Assumes COEF_W + ERR_W <= ACC_W and OUT_W <= ACC_W.
module steer_loop_filter
    import steer_lf_pkg::*;
#(
    parameter int unsigned ERR_W    = 16,
    parameter int unsigned COEF_W   = 12,
    parameter int unsigned ACC_W    = 32,
    parameter int unsigned OUT_W    = 24,
    parameter int unsigned LOCK_RUN = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe_i,
    input  logic                     freeze_i,
    input  logic signed [ERR_W-1:0]  phase_err_i,
    input  logic signed [COEF_W-1:0] gain_prop_i,
    input  logic signed [COEF_W-1:0] gain_rate_i,
    input  logic signed [COEF_W-1:0] gain_accel_i,
    input  logic        [ERR_W-1:0]  lock_thresh_i,
    output logic signed [OUT_W-1:0]  freq_adj_o,
    output logic                     locked_o
);

    localparam int unsigned PROD_W = ERR_W + COEF_W;

    logic                     accept;
    logic signed [COEF_W-1:0] gain_a [NUM_GAINS];
    logic signed [PROD_W-1:0] prod_a [NUM_GAINS];
    logic signed [ACC_W-1:0]  acc_rate_q;
    logic signed [ACC_W-1:0]  acc_accel_q;
    logic signed [ACC_W-1:0]  acc_rate_nx;
    logic signed [ACC_W-1:0]  acc_accel_nx;

    // An update counts only when it is not held off by freeze
    always_comb begin
        accept = strobe_i & ~freeze_i;
    end

    // Collect the gains into one array indexed by path
    always_comb begin
        gain_a[G_PROP]  = gain_prop_i;
        gain_a[G_RATE]  = gain_rate_i;
        gain_a[G_ACCEL] = gain_accel_i;
    end

    // One multiplier per gain path
    for (genvar k = 0; k < NUM_GAINS; k++) begin : g_mul
        lf_gain_mul #(
            .ERR_W  (ERR_W),
            .COEF_W (COEF_W)
        ) i_mul (
            .err_i  (phase_err_i),
            .gain_i (gain_a[k]),
            .prod_o (prod_a[k])
        );
    end

    // Acceleration path: previous value plus the acceleration product
    lf_sat_add #(
        .W  (ACC_W),
        .IW (PROD_W)
    ) i_add_accel (
        .base_i  (acc_accel_q),
        .inc_i   (prod_a[G_ACCEL]),
        .carry_i ('0),
        .sum_o   (acc_accel_nx)
    );

    // Rate path: previous value plus the rate product plus the old acceleration
    lf_sat_add #(
        .W  (ACC_W),
        .IW (PROD_W)
    ) i_add_rate (
        .base_i  (acc_rate_q),
        .inc_i   (prod_a[G_RATE]),
        .carry_i (acc_accel_q),
        .sum_o   (acc_rate_nx)
    );

    // Accumulator registers, advanced once per accepted update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_accel_q <= '0;
            acc_rate_q  <= '0;
        end else if (accept) begin
            acc_accel_q <= acc_accel_nx;
            acc_rate_q  <= acc_rate_nx;
        end
    end

    // Output word: proportional product plus the new rate accumulator
    lf_out_stage #(
        .IW    (ACC_W),
        .PW    (PROD_W),
        .OUT_W (OUT_W)
    ) i_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (accept),
        .prop_i (prod_a[G_PROP]),
        .base_i (acc_rate_nx),
        .q_o    (freq_adj_o)
    );

    // Lock detection on the raw error samples
    lf_lock_det #(
        .ERR_W   (ERR_W),
        .RUN_LEN (LOCK_RUN)
    ) i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (accept),
        .err_i    (phase_err_i),
        .thresh_i (lock_thresh_i),
        .locked_o (locked_o)
    );

endmodule

// File: rtl/steer_lf_checker.sv
// steer_lf_checker: port-level temporal properties of steer_loop_filter.
// It is attached to every instance through the bind statement below.
module steer_lf_checker #(
    parameter int unsigned ERR_W = 16,
    parameter int unsigned OUT_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    strobe_i,
    input logic                    freeze_i,
    input logic signed [ERR_W-1:0] phase_err_i,
    input logic        [ERR_W-1:0] lock_thresh_i,
    input logic signed [OUT_W-1:0] freq_adj_o,
    input logic                    locked_o
);

    logic [ERR_W-1:0] err_mag;

    // Independent magnitude of the incoming error
    always_comb begin
        err_mag = phase_err_i[ERR_W-1] ? (~$unsigned(phase_err_i) + 1'b1)
                                       : $unsigned(phase_err_i);
    end

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (freq_adj_o == '0 && !locked_o));

    // R4: without a strobe, the outputs hold
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(freq_adj_o) && $stable(locked_o)));

    // R7: freeze holds the outputs even when a strobe arrives
    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> ($stable(freq_adj_o) && $stable(locked_o)));

    // R8: lock can only rise on an accepted sample below the threshold
    p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(strobe_i && !freeze_i && (err_mag < lock_thresh_i)));

    // R9: an accepted sample at or above the threshold drops lock
    p_lock_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !freeze_i && (err_mag >= lock_thresh_i)) |=> !locked_o);

endmodule

bind steer_loop_filter steer_lf_checker #(
    .ERR_W (ERR_W),
    .OUT_W (OUT_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe_i      (strobe_i),
    .freeze_i      (freeze_i),
    .phase_err_i   (phase_err_i),
    .lock_thresh_i (lock_thresh_i),
    .freq_adj_o    (freq_adj_o),
    .locked_o      (locked_o)
);

// File: tb/test_steer_loop_filter.sv
// Bench for steer_loop_filter: a behavioural model built on integers is
// advanced at each rising edge, and the outputs are compared with it at
// every falling edge.
module test_steer_loop_filter;

    localparam int CLK_PERIOD = 10;
    localparam int EW  = 10;
    localparam int CW  = 8;
    localparam int AW  = 20;
    localparam int OW  = 20;
    localparam int RUN = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 strobe = 1'b0;
    logic                 freeze = 1'b0;
    logic signed [EW-1:0] perr = '0;
    logic signed [CW-1:0] g_p = '0;
    logic signed [CW-1:0] g_r = '0;
    logic signed [CW-1:0] g_a = '0;
    logic        [EW-1:0] thr = '0;
    logic signed [OW-1:0] fadj;
    logic                 lock;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";

    longint m_rate = 0;
    longint m_accel = 0;
    longint m_out = 0;
    int     m_run = 0;
    bit     m_lock = 1'b0;

    steer_loop_filter #(
        .ERR_W    (EW),
        .COEF_W   (CW),
        .ACC_W    (AW),
        .OUT_W    (OW),
        .LOCK_RUN (RUN)
    ) i_steer_loop_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe_i      (strobe),
        .freeze_i      (freeze),
        .phase_err_i   (perr),
        .gain_prop_i   (g_p),
        .gain_rate_i   (g_r),
        .gain_accel_i  (g_a),
        .lock_thresh_i (thr),
        .freq_adj_o    (fadj),
        .locked_o      (lock)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint clampw(longint v, int w);
        longint hi = (longint'(1) <<< (w-1)) - 1;
        longint lo = -(longint'(1) <<< (w-1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Reference model, advanced at each rising edge
    always @(posedge clk) begin
        longint e;
        longint mag;
        longint n_acc;
        longint n_rate;
        if (!rst_n) begin
            m_rate = 0; m_accel = 0; m_out = 0; m_run = 0; m_lock = 1'b0;
        end else if (strobe && !freeze) begin
            e      = longint'(perr);
            n_acc  = clampw(m_accel + longint'(g_a) * e, AW);
            n_rate = clampw(m_rate + longint'(g_r) * e + m_accel, AW);
            m_out  = clampw(longint'(g_p) * e + n_rate, OW);
            m_accel = n_acc;
            m_rate  = n_rate;
            mag = (e < 0) ? -e : e;
            if (mag < longint'(thr)) begin
                if (m_run < RUN) m_run++;
                m_lock = (m_run >= RUN);
            end else begin
                m_run = 0;
                m_lock = 1'b0;
            end
        end
    end

    task automatic compare();
        n_checks++;
        if (longint'(fadj) != m_out) begin
            n_fails++;
            $display("FAIL %s freq_adj actual %0d expected %0d at %0t", cur_req, fadj, m_out, $time);
        end
        n_checks++;
        if (lock != m_lock) begin
            n_fails++;
            $display("FAIL %s locked actual %0d expected %0d at %0t", cur_req, lock, m_lock, $time);
        end
    endtask

    // One clock: the rising edge, then a comparison at the falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    // One strobe with the given error, followed by one idle cycle
    task automatic pulse(input int e);
        perr = EW'(e);
        strobe = 1'b1;
        cyc();
        strobe = 1'b0;
        cyc();
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc();
        rst_n = 1'b1;
        cyc();

        // R2, R3: the integrating paths under a mixed error pattern
        g_p = 8'sd5; g_r = 8'sd3; g_a = 8'sd2; thr = 10'd1000;
        cur_req = "R2";
        pulse(7); pulse(-3); pulse(0);
        cur_req = "R3";
        pulse(12); pulse(-40); pulse(100); pulse(-512); pulse(511);
        // R4: output holds across idle cycles
        cur_req = "R4";
        for (int i = 0; i < 6; i++) cyc();
        pulse(1);

        // R5: drive both accumulators into positive saturation
        cur_req = "R5";
        g_p = 8'sd0; g_r = 8'sd0; g_a = 8'sd127;
        for (int i = 0; i < 30; i++) pulse(511);
        g_a = 8'sd0;
        pulse(0); pulse(0);
        // R6: positive output clamp
        cur_req = "R6";
        g_p = 8'sd127;
        pulse(511);
        // R5: swing to negative saturation
        cur_req = "R5";
        g_p = 8'sd0; g_a = -8'sd128;
        for (int i = 0; i < 40; i++) pulse(511);
        g_a = 8'sd0;
        pulse(3);
        // R6: negative output clamp
        cur_req = "R6";
        g_p = 8'sd127;
        pulse(-512);
        pulse(511);

        // R8: lock after the full run, strobes back to back
        cur_req = "R1";
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        g_p = 8'sd1; g_r = 8'sd0; g_a = 8'sd0; thr = 10'd20;
        cur_req = "R8";
        strobe = 1'b1;
        for (int i = 0; i < RUN - 1; i++) begin
            perr = EW'((i % 39) - 19);
            cyc();
        end
        perr = -10'sd19;
        cyc();
        strobe = 1'b0;
        cyc();

        // R7: freeze ignores strobes, including a large error
        cur_req = "R7";
        freeze = 1'b1;
        g_r = 8'sd50; g_a = 8'sd50;
        pulse(300); pulse(-300);
        freeze = 1'b0;
        g_r = 8'sd0; g_a = 8'sd0;
        pulse(2);

        // R9: an error exactly at the threshold drops lock
        cur_req = "R9";
        pulse(20);
        for (int i = 0; i < 30; i++) pulse(5);
        pulse(-20);
        // R8: the most negative code counts as a large magnitude
        cur_req = "R8";
        thr = 10'd1023;
        strobe = 1'b1;
        perr = -10'sd512;
        for (int i = 0; i < RUN + 2; i++) cyc();
        strobe = 1'b0;
        cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule